// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This block is an 8-bit up-counter that advances on ticks from a free-running 14-bit prescaler of the peripheral clock. A 3-bit clock-select field picks one of eight prescaler taps. Software loads the counter and a small control/status register through two write strobes. Both values can always be read back on output buses.

The block has two modes. In interval mode, reaching the top count 0xFF sets an overflow flag. That flag drives an interrupt line, and the counter then wraps and keeps counting. In watchdog mode, reaching 0xFF starts a fixed-length overflow pulse on an output pin and raises a single-cycle reset request.

The prescaler never stops and is never cleared by the enable bit. As a result, the first increment after enabling can come anywhere from one cycle to one full divided period later.

Top module: `dualWatchdog`

## Requirements
- R1: After reset the counter reads 0x00, every control/status field reads 0 (which selects interval mode), and intervalIrq, ovfOut and rstReq are low.
- R2: A counter write with cntWrEn loads cntWrData, and the value is visible on the next cycle. If an increment would occur in that same cycle, the write wins.
- R3: The clock-select field (CSR bits [2:0]) gives increments spaced 1, 64, 128, 256, 512, 1024, 4096 or 16384 cycles apart for codes 0 to 7. These come from a 14-bit prescaler that is cleared only by reset.
- R4: The first increment appears 1 to N cycles after the run bit (CSR bit 3) becomes visible in csrValue, where N is the selected ratio.
- R5: While the run bit is 0, the counter holds its value. Only a counter write changes it.
- R6: In interval mode (CSR bit 4 = 0), the cycle after the counter first shows 0xFF, the flag (CSR bit 5) reads 1. When running, the counter continues to 0x00 at the same time. intervalIrq equals the flag while in interval mode.
- R7: Writing 0xFF to the counter causes an overflow event immediately, whatever the run bit or the clock-select field is.
- R8: A CSR write with bit 5 = 0 clears the flag, unless the counter holds 0xFF in that cycle, in which case the flag stays set. Writing bit 5 = 1 never sets the flag. An overflow in the same cycle as a clear wins over the clear.
- R9: In watchdog mode (CSR bit 4 = 1), an overflow drives ovfOut high for exactly 128 cycles and rstReq high for exactly one cycle, both starting the cycle after the counter first shows 0xFF. The flag and intervalIrq stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 8 | Value loaded into the counter |
| csrWrEn | input | 1 | Control/status write strobe |
| csrWrData | input | 6 | {flag, mode, run, clkSel[2:0]} |
| cntValue | output | 8 | Current counter value |
| csrValue | output | 6 | {flag, mode, run, clkSel[2:0]} |
| intervalIrq | output | 1 | Interval-mode overflow interrupt |
| ovfOut | output | 1 | Watchdog overflow pulse |
| rstReq | output | 1 | Single-cycle watchdog reset request |

## Verification
The embedded properties assume that every input is a known value, sampled synchronously to clk, and that reset is applied for at least one clock edge before checking begins. They place no limit on how often the strobes fire or on the data values, so back-to-back writes and writes that collide with ticks are legal. The stimulus drives every input from a defined value on the falling edge. Random writes favour counts near 0xFF and the fast clock selects, so overflows, flag clears at the top count, and write/tick collisions all occur often.

// File: rtl/dualWatchdogPkg.sv
package dualWatchdogPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntLoad;
    logic       countEn;
    logic [2:0] clkSel;
  } dpCtrlT;

  // prescaler bit whose rising edge paces each clock-select code (code 0 ticks every cycle)
  function automatic int tapBit(input int sel);
    case (sel)
      1: return 5;
      2: return 6;
      3: return 7;
      4: return 8;
      5: return 9;
      6: return 11;
      7: return 13;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/dualWatchdogDp.sv
module dualWatchdogDp
  import dualWatchdogPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 14,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrlT           ctl,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             cntIsMax,
  output logic             ovfEvent
);

  localparam int NUM_SEL = 1 << SEL_W;

  logic [PRE_W-1:0] preCnt;
  logic [NUM_SEL-1:0] tapHit;
  logic tick;
  logic atMaxQ;

  // free-running prescaler, untouched by the enable bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  // tick fires on the cycle before the selected tap bit rises
  for (genvar g = 0; g < NUM_SEL; g++) begin : gTap
    if (g == 0) begin : gDirect
      assign tapHit[g] = 1'b1;
    end else begin : gDivided
      localparam int TB = tapBit(g);
      localparam logic [PRE_W-1:0] EDGE_PT = PRE_W'((1 << TB) - 1);
      assign tapHit[g] = (preCnt[TB:0] == EDGE_PT[TB:0]);
    end
  end

  assign tick = tapHit[ctl.clkSel];

  // a write beats a simultaneous increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (ctl.cntLoad)          cnt <= wrData;
    else if (ctl.countEn && tick)  cnt <= cnt + CNT_W'(1);
  end

  assign cntIsMax = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) atMaxQ <= 1'b0;
    else       atMaxQ <= cntIsMax;
  end

  // overflow is the first cycle the counter shows all ones
  assign ovfEvent = cntIsMax && !atMaxQ;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntLoad |=> cnt == $past(wrData)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntLoad && !ctl.countEn) |=> cnt == $past(cnt)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.cntLoad |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R3
  AST_OVF_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> !ovfEvent); // R6

endmodule

// File: rtl/dualWatchdogCtrl.sv
module dualWatchdogCtrl
  import dualWatchdogPkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int CSR_W     = SEL_W + 3,
  parameter int PULSE_LEN = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  input  logic             cntIsMax,
  input  logic             ovfEvent,
  output dpCtrlT           ctl,
  output logic [CSR_W-1:0] csrValue,
  output logic             intervalIrq,
  output logic             ovfOut,
  output logic             rstReq
);

  localparam int RUN_BIT  = SEL_W;
  localparam int MODE_BIT = SEL_W + 1;
  localparam int FLAG_BIT = SEL_W + 2;
  localparam int PL_W     = $clog2(PULSE_LEN + 1);

  logic             runQ;
  logic             modeQ;   // 1 = watchdog
  logic             flagQ;
  logic [SEL_W-1:0] selQ;
  logic [PL_W-1:0]  pulseLeft;
  logic             rstReqQ;
  logic             wdogHit;
  logic             intvHit;

  assign wdogHit = ovfEvent && modeQ;
  assign intvHit = ovfEvent && !modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      modeQ <= 1'b0;
      selQ  <= '0;
    end else if (csrWrEn) begin
      runQ  <= csrWrData[RUN_BIT];
      modeQ <= csrWrData[MODE_BIT];
      selQ  <= csrWrData[SEL_W-1:0];
    end
  end

  // set beats clear; a clear is refused while the counter shows all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          flagQ <= 1'b0;
    else if (intvHit)                                   flagQ <= 1'b1;
    else if (csrWrEn && !csrWrData[FLAG_BIT] && !cntIsMax) flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseLeft <= '0;
    else if (wdogHit)          pulseLeft <= PL_W'(PULSE_LEN);
    else if (pulseLeft != '0)  pulseLeft <= pulseLeft - PL_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReqQ <= 1'b0;
    else       rstReqQ <= wdogHit;
  end

  assign ctl.cntLoad = cntWrEn;
  assign ctl.countEn = runQ;
  assign ctl.clkSel  = selQ;

  assign csrValue    = {flagQ, modeQ, runQ, selQ};
  assign intervalIrq = flagQ && !modeQ;
  assign ovfOut      = (pulseLeft != '0);
  assign rstReq      = rstReqQ;

  AST_FLAG_HELD_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && cntIsMax) |=> flagQ); // R8
  AST_INTERVAL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    intvHit |=> flagQ); // R6
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdogHit |=> (ovfOut && rstReq)); // R9
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R9

endmodule

// File: rtl/dualWatchdog.sv
module dualWatchdog
  import dualWatchdogPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 128,
  localparam int CSR_W    = SEL_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic [CNT_W-1:0] cntValue,
  output logic [CSR_W-1:0] csrValue,
  output logic             intervalIrq,
  output logic             ovfOut,
  output logic             rstReq
);

  dpCtrlT dpCtl;
  logic   cntIsMax;
  logic   ovfEvent;

  dualWatchdogCtrl #(
    .SEL_W    (SEL_W),
    .CSR_W    (CSR_W),
    .PULSE_LEN(PULSE_LEN)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntWrEn    (cntWrEn),
    .csrWrEn    (csrWrEn),
    .csrWrData  (csrWrData),
    .cntIsMax   (cntIsMax),
    .ovfEvent   (ovfEvent),
    .ctl        (dpCtl),
    .csrValue   (csrValue),
    .intervalIrq(intervalIrq),
    .ovfOut     (ovfOut),
    .rstReq     (rstReq)
  );

  dualWatchdogDp #(
    .CNT_W(CNT_W),
    .PRE_W(PRE_W),
    .SEL_W(SEL_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .wrData  (cntWrData),
    .cnt     (cntValue),
    .cntIsMax(cntIsMax),
    .ovfEvent(ovfEvent)
  );

endmodule

// File: tb/tb_dualWatchdog.sv
module tb_dualWatchdog;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = 8'h00;
  logic       csrWrEn = 1'b0;
  logic [5:0] csrWrData = 6'h00;
  logic [7:0] cntValue;
  logic [5:0] csrValue;
  logic       intervalIrq, ovfOut, rstReq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dualWatchdog dut (
    .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .cntValue(cntValue),
    .csrValue(csrValue), .intervalIrq(intervalIrq), .ovfOut(ovfOut), .rstReq(rstReq)
  );

  // ---- expected-value model built from the requirements ----
  int       mPre = 0;
  logic [7:0] mCnt = 0;
  bit       mAtMax = 0, mFlag = 0, mMode = 0, mRun = 0, mRst = 0;
  logic [2:0] mSel = 0;
  int       mPulse = 0;

  function automatic int divOf(input logic [2:0] s);
    case (s)
      3'd0: return 1;     3'd1: return 64;   3'd2: return 128;  3'd3: return 256;
      3'd4: return 512;   3'd5: return 1024; 3'd6: return 4096; default: return 16384;
    endcase
  endfunction

  function automatic bit tickFor(input int pre, input logic [2:0] s);
    int r;
    r = divOf(s);
    if (r == 1) return 1'b1;
    return (pre % r) == (r / 2 - 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mAtMax = 0; mFlag = 0; mMode = 0; mRun = 0;
      mSel = 0; mPulse = 0; mRst = 0;
    end else begin
      bit ev;
      logic [7:0] nCnt;
      ev = (mCnt == 8'hFF) && !mAtMax;
      if (cntWrEn) nCnt = cntWrData;
      else if (mRun && tickFor(mPre, mSel)) nCnt = mCnt + 8'd1;
      else nCnt = mCnt;
      if (ev && !mMode) mFlag = 1;
      else if (csrWrEn && !csrWrData[5] && mCnt != 8'hFF) mFlag = 0;
      if (ev && mMode) begin mPulse = 128; mRst = 1; end
      else begin mRst = 0; if (mPulse > 0) mPulse = mPulse - 1; end
      if (csrWrEn) begin mMode = csrWrData[4]; mRun = csrWrData[3]; mSel = csrWrData[2:0]; end
      mAtMax = (mCnt == 8'hFF);
      mCnt = nCnt;
      mPre = (mPre + 1) % 16384;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(cntValue == mCnt, "R2", "cntValue", cntValue, mCnt);
      check(csrValue == {mFlag, mMode, mRun, mSel}, "R8", "csrValue", csrValue, {mFlag, mMode, mRun, mSel});
      check(intervalIrq == (mFlag && !mMode), "R6", "intervalIrq", intervalIrq, mFlag && !mMode);
      check(ovfOut == (mPulse > 0), "R9", "ovfOut", ovfOut, mPulse > 0);
      check(rstReq == mRst, "R9", "rstReq", rstReq, mRst);
    end
  end

  task automatic wrCnt(input logic [7:0] v);
    @(negedge clk); cntWrEn = 1; cntWrData = v;
    @(negedge clk); cntWrEn = 0;
  endtask

  task automatic wrCsr(input logic [5:0] v);
    @(negedge clk); csrWrEn = 1; csrWrData = v;
    @(negedge clk); csrWrEn = 0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(cntValue == 8'h00, "R1", "cnt after reset", cntValue, 0);
    check(csrValue == 6'h00, "R1", "csr after reset", csrValue, 0);
    check(!intervalIrq && !ovfOut && !rstReq, "R1", "outputs after reset",
          {intervalIrq, ovfOut, rstReq}, 0);

    // R7 writing 0xFF overflows at once with run off and slowest select
    wrCsr(6'h07);
    wrCnt(8'hFF);
    @(negedge clk);
    check(csrValue[5] == 1'b1, "R7", "flag after 0xFF write", csrValue[5], 1);
    check(intervalIrq == 1'b1, "R7", "irq after 0xFF write", intervalIrq, 1);

    // R8 clear refused at 0xFF, accepted after rewrite, bit5=1 never sets
    wrCsr(6'h07);
    check(csrValue[5] == 1'b1, "R8", "flag kept at 0xFF", csrValue[5], 1);
    wrCnt(8'h00);
    wrCsr(6'h07);
    check(csrValue[5] == 1'b0, "R8", "flag cleared", csrValue[5], 0);
    wrCsr(6'h27 | 6'h00); wrCsr(6'h07);
    wrCsr(6'h27);
    check(csrValue[5] == 1'b0, "R8", "writing 1 does not set flag", csrValue[5], 0);
    wrCsr(6'h00);

    // R6 interval overflow and wrap
    wrCnt(8'hFC);
    wrCsr(6'h08);
    while (cntValue != 8'hFF) @(negedge clk);
    check(csrValue[5] == 1'b0, "R6", "flag while first 0xFF", csrValue[5], 0);
    @(negedge clk);
    check(cntValue == 8'h00, "R6", "wrap to 0x00", cntValue, 0);
    check(csrValue[5] && intervalIrq, "R6", "flag+irq after 0xFF", {csrValue[5], intervalIrq}, 3);

    // R5 stopped counter holds
    wrCsr(6'h00);
    begin
      logic [7:0] held;
      held = cntValue;
      repeat (50) @(negedge clk);
      check(cntValue == held, "R5", "count held while stopped", cntValue, held);
    end

    // R2 write beats increment (sel 0 ticks every cycle)
    wrCsr(6'h08);
    wrCnt(8'h10);
    check(cntValue == 8'h10, "R2", "write wins over tick", cntValue, 8'h10);
    wrCsr(6'h00);

    // R4 first-increment window and R3 spacing
    foreach (selList[i]) begin
      int r, k, j;
      r = divOf(selList[i]);
      for (int ph = 0; ph < 3; ph++) begin
        wrCnt(8'h00);
        repeat ($urandom % (r + 1)) @(negedge clk);
        wrCsr({3'b001, selList[i]});
        k = 0;
        while (cntValue != 8'h01 && k < r + 5) begin @(negedge clk); k++; end
        check(k >= 1 && k <= r, "R4", "first increment delay", k, r);
        j = 0;
        while (cntValue != 8'h02 && j < r + 5) begin @(negedge clk); j++; end
        check(j == r, "R3", "increment spacing", j, r);
        wrCsr(6'h00);
      end
    end

    // R9 watchdog pulse
    wrCsr(6'h10);
    wrCnt(8'hFF);
    begin
      int hiOvf = 0, hiRst = 0, hiIrq = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (ovfOut) hiOvf++;
        if (rstReq) hiRst++;
        if (intervalIrq || csrValue[5]) hiIrq++;
      end
      check(hiOvf == 128, "R9", "ovfOut length", hiOvf, 128);
      check(hiRst == 1, "R9", "rstReq length", hiRst, 1);
      check(hiIrq == 0, "R9", "no flag in watchdog", hiIrq, 0);
    end
    wrCnt(8'h00);
    wrCsr(6'h00);

    // random traffic against the model
    for (int n = 0; n < 8000; n++) begin
      int p;
      @(negedge clk);
      cntWrEn = 0; csrWrEn = 0;
      p = $urandom % 100;
      if (p < 4) begin
        cntWrEn = 1;
        case ($urandom % 4)
          0: cntWrData = 8'h00;
          1: cntWrData = 8'hFF;
          2: cntWrData = 8'hF8 + 8'($urandom % 8);
          default: cntWrData = 8'($urandom);
        endcase
      end else if (p < 7) begin
        csrWrEn = 1;
        csrWrData[5:3] = 3'($urandom);
        csrWrData[2:0] = (($urandom % 10) < 7) ? 3'($urandom % 2) : 3'($urandom);
      end
    end
    @(negedge clk); cntWrEn = 0; csrWrEn = 0;
    repeat (3) @(negedge clk);
    finishRun();
  end

  logic [2:0] selList [5] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd6};

endmodule